// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank State Tracker

This block watches the control pins of an SDRAM command bus: chip select, the three strobes, the bank-select pair and the address bus. It turns each sampled pin pattern into a one-hot command code and the bank that the command addresses. It also keeps an open/closed flag for every bank and reports, in the same cycle as the command code, any command that is not allowed in the current bank states. A copy of the last accepted mode-register write is taken from the address bus. A monitor or a controller self-check can use the block to follow the device state without modelling the memory array.

Everything is sampled on the rising clock edge. All outputs come from registers, so the outputs for a command sampled at edge k are visible after edge k. The tracker state that those outputs describe already includes the effect of that command. A clock-enable input is registered, and a low value at one edge suppresses decoding at the next edge. A completion pulse, which names a bank, closes a bank whose last read or write asked for automatic precharge.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: When chip select is high at a decoding edge, the command code is the deselect code (bit 0), the reported bank is 0, the illegal flag is low, and bank states and mode register do not change.
- R2: With chip select low, the strobe patterns (ras_n, cas_n, we_n) decode as follows: L,H,H is activate (bit 2); L,H,L with A10 low is single-bank precharge (bit 3); L,H,L with A10 high is precharge-all (bit 4); H,L,H is read (bit 5); H,L,L is write (bit 6). The reported bank is the sampled bank-select value.
- R3: H,H,H decodes as no-operation (bit 1), H,H,L as burst stop (bit 7), L,L,L as mode-register write (bit 8) and L,L,H as refresh (bit 9). None of these changes any bank state.
- R4: Activate to an idle bank opens it. Activate to a bank that is already open raises the illegal flag and leaves all states unchanged.
- R5: Single-bank precharge closes only the addressed bank. Precharge-all closes every bank, is never illegal, and is accepted when some or all banks are already idle.
- R6: Read or write sets the auto-precharge output to the sampled A10. Read or write to an idle bank raises the illegal flag for one cycle and changes no state.
- R7: A mode-register write with all banks idle loads mode_reg, with bit 10 taken from A11 and bits 9:0 from A9..A0. With any bank open, the flag is raised and mode_reg keeps its value.
- R8: Refresh with any bank open raises the illegal flag. With all banks idle it is legal.
- R9: A pulse on burst_done closes the bank named by done_bank only if that bank's last accepted read or write had A10 high. Otherwise the pulse has no effect. A same-edge command to that bank is judged on the state before the edge, and a legal command takes effect over the pulse.
- R10: When clock enable was low at the previous edge, the command code is all zeros, the illegal flag and the auto-precharge output are low, and neither commands nor burst_done change any state.
- R11: After reset all outputs are zero, all banks are idle, and clock enable is taken as previously high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable; its registered value gates the next decode |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | 2 | Bank select |
| addr | input | 12 | Address bus (A10 qualifier, mode value) |
| burst_done | input | 1 | Pulse: burst of done_bank has finished |
| done_bank | input | 2 | Bank whose burst finished |
| cmd_onehot | output | 10 | One-hot command code of the last decoded edge |
| cmd_bank | output | 2 | Bank addressed by that command |
| auto_pre | output | 1 | Read/write carried auto precharge |
| illegal | output | 1 | Command forbidden by the bank states |
| bank_open | output | 4 | Per-bank open flag, bit n for bank n |
| mode_reg | output | 11 | Last accepted mode-register value |

## Verification
The assertions assume that every input is a settled 0 or 1 at each rising edge and that reset is held for at least one edge. Apart from that, they place no limit on command order, because illegal sequences are part of the specified behaviour. The stimulus changes inputs only on the falling edge. It walks through every pin pattern, including the clock-enable lag and completion pulses for banks with and without a pending automatic precharge, and then runs a long random mix. In that mix, chip select is sometimes high, clock enable sometimes drops, and completion pulses arrive at random.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    localparam int NUM_CMDS = 10;

    typedef enum logic [3:0] {
        CI_DESEL = 4'd0,
        CI_NOP   = 4'd1,
        CI_ACT   = 4'd2,
        CI_PRE   = 4'd3,
        CI_PALL  = 4'd4,
        CI_RD    = 4'd5,
        CI_WR    = 4'd6,
        CI_BST   = 4'd7,
        CI_MRS   = 4'd8,
        CI_REF   = 4'd9
    } cmd_idx_e;

    typedef struct packed {
        cmd_idx_e idx;
        logic     ap;
    } dec_t;

    function automatic logic [NUM_CMDS-1:0] idx_to_onehot(input cmd_idx_e i);
        logic [NUM_CMDS-1:0] v;
        v = '0;
        v[i] = 1'b1;
        return v;
    endfunction

    function automatic logic is_column(input cmd_idx_e i);
        return (i == CI_RD) || (i == CI_WR);
    endfunction

endpackage

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
    import sdcmd_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic a10,
    output dec_t dec
);
    always_comb begin
        dec.ap  = 1'b0;
        dec.idx = CI_DESEL;
        if (!cs_n) begin
            unique case ({ras_n, cas_n, we_n})
                3'b111:  dec.idx = CI_NOP;
                3'b011:  dec.idx = CI_ACT;
                3'b010:  dec.idx = a10 ? CI_PALL : CI_PRE;
                3'b101:  dec.idx = CI_RD;
                3'b100:  dec.idx = CI_WR;
                3'b110:  dec.idx = CI_BST;
                3'b000:  dec.idx = CI_MRS;
                default: dec.idx = CI_REF;
            endcase
            dec.ap = is_column(dec.idx) & a10;
        end
    end
endmodule

// File: rtl/sdcmd_bank_tracker.sv
module sdcmd_bank_tracker
    import sdcmd_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    localparam int BA_W = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  cmd_idx_e             idx,
    input  logic [BA_W-1:0]      bank,
    input  logic                 a10,
    input  logic                 done,
    input  logic [BA_W-1:0]      done_bank,
    output logic [NUM_BANKS-1:0] open_vec,
    output logic                 illegal_c,
    output logic                 all_idle
);
    assign all_idle = ~|open_vec;

    always_comb begin
        illegal_c = 1'b0;
        if (en) begin
            case (idx)
                CI_ACT:         illegal_c = open_vec[bank];
                CI_RD, CI_WR:   illegal_c = ~open_vec[bank];
                CI_MRS, CI_REF: illegal_c = ~all_idle;
                default:        illegal_c = 1'b0;
            endcase
        end
    end

    logic [NUM_BANKS-1:0] pend_vec;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic sel;
        logic act_r;
        logic pend_r;
        assign sel = (bank == BA_W'(b));

        always_ff @(posedge clk) begin
            if (rst) begin
                act_r  <= 1'b0;
                pend_r <= 1'b0;
            end else if (en) begin
                if (done && done_bank == BA_W'(b) && pend_r) begin
                    act_r  <= 1'b0;
                    pend_r <= 1'b0;
                end
                if (!illegal_c) begin
                    case (idx)
                        CI_ACT: if (sel) begin
                            act_r  <= 1'b1;
                            pend_r <= 1'b0;
                        end
                        CI_PRE: if (sel) begin
                            act_r  <= 1'b0;
                            pend_r <= 1'b0;
                        end
                        CI_PALL: begin
                            act_r  <= 1'b0;
                            pend_r <= 1'b0;
                        end
                        CI_RD, CI_WR: if (sel) begin
                            act_r  <= 1'b1;
                            pend_r <= a10;
                        end
                        default: ;
                    endcase
                end
            end
        end
        assign open_vec[b] = act_r;
        assign pend_vec[b] = pend_r;
    end

    // R4: an activate to an idle bank leaves it open
    a_r4_act_opens: assert property (@(posedge clk) disable iff (rst)
        (en && idx == CI_ACT && !open_vec[bank]) |=> open_vec[$past(bank)]);

    // R5: precharge-all leaves every bank idle
    a_r5_pall_closes: assert property (@(posedge clk) disable iff (rst)
        (en && idx == CI_PALL) |=> (open_vec == '0));

    // R10: a masked edge changes no bank state
    a_r10_masked_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(open_vec) && $stable(pend_vec)));

    // R9: a pending auto precharge only exists on an open bank
    a_r9_pend_on_open: assert property (@(posedge clk) disable iff (rst)
        ((pend_vec & ~open_vec) == '0));
endmodule

// File: rtl/sdcmd_mode_reg.sv
module sdcmd_mode_reg #(
    parameter int ADDR_W = 12,
    parameter int AP_BIT = 10,
    localparam int MODE_W = ADDR_W - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr,
    output logic [MODE_W-1:0] mode
);
    logic [MODE_W-1:0] packed_val;
    assign packed_val = {addr[ADDR_W-1:AP_BIT+1], addr[AP_BIT-1:0]};

    always_ff @(posedge clk) begin
        if (rst)       mode <= '0;
        else if (load) mode <= packed_val;
    end

    // R7: mode value only changes on an accepted load
    a_r7_mode_hold: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(mode));
endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
    import sdcmd_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 12,
    parameter int AP_BIT    = 10,
    localparam int BA_W     = $clog2(NUM_BANKS),
    localparam int MODE_W   = ADDR_W - 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cke,
    input  logic                 cs_n,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic [BA_W-1:0]      ba,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 burst_done,
    input  logic [BA_W-1:0]      done_bank,
    output logic [NUM_CMDS-1:0]  cmd_onehot,
    output logic [BA_W-1:0]      cmd_bank,
    output logic                 auto_pre,
    output logic                 illegal,
    output logic [NUM_BANKS-1:0] bank_open,
    output logic [MODE_W-1:0]    mode_reg
);
    logic cke_q;
    dec_t dec;
    logic ill_c;
    logic idle_all;

    always_ff @(posedge clk) begin
        if (rst) cke_q <= 1'b1;
        else     cke_q <= cke;
    end

    sdcmd_decode u_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .a10   (addr[AP_BIT]),
        .dec   (dec)
    );

    sdcmd_bank_tracker #(.NUM_BANKS(NUM_BANKS)) u_banks (
        .clk       (clk),
        .rst       (rst),
        .en        (cke_q),
        .idx       (dec.idx),
        .bank      (ba),
        .a10       (addr[AP_BIT]),
        .done      (burst_done),
        .done_bank (done_bank),
        .open_vec  (bank_open),
        .illegal_c (ill_c),
        .all_idle  (idle_all)
    );

    sdcmd_mode_reg #(.ADDR_W(ADDR_W), .AP_BIT(AP_BIT)) u_mode (
        .clk  (clk),
        .rst  (rst),
        .load (cke_q && dec.idx == CI_MRS && idle_all),
        .addr (addr),
        .mode (mode_reg)
    );

    always_ff @(posedge clk) begin
        if (rst || !cke_q) begin
            cmd_onehot <= '0;
            cmd_bank   <= '0;
            auto_pre   <= 1'b0;
            illegal    <= 1'b0;
        end else begin
            cmd_onehot <= idx_to_onehot(dec.idx);
            cmd_bank   <= (dec.idx == CI_DESEL) ? '0 : ba;
            auto_pre   <= dec.ap;
            illegal    <= ill_c;
        end
    end

    // R1: at most one command bit is reported at a time
    a_r1_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cmd_onehot));

    // R10: a low registered clock enable yields an empty report
    a_r10_no_cmd: assert property (@(posedge clk) disable iff (rst)
        !cke_q |=> (cmd_onehot == '0 && !illegal && !auto_pre));

    // R6: auto precharge is reported only with a column command
    a_r6_ap_column: assert property (@(posedge clk) disable iff (rst)
        auto_pre |-> (cmd_onehot[CI_RD] || cmd_onehot[CI_WR]));
endmodule

// File: tb/sdram_cmd_tracker_tb.sv
module sdram_cmd_tracker_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0] ba = '0;
    logic [11:0] addr = '0;
    logic bdone = 1'b0;
    logic [1:0] dbank = '0;

    logic [9:0]  cmd_onehot;
    logic [1:0]  cmd_bank;
    logic        auto_pre, illegal;
    logic [3:0]  bank_open;
    logic [10:0] mode_reg;

    sdram_cmd_tracker u_dut (
        .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
        .burst_done(bdone), .done_bank(dbank),
        .cmd_onehot(cmd_onehot), .cmd_bank(cmd_bank), .auto_pre(auto_pre),
        .illegal(illegal), .bank_open(bank_open), .mode_reg(mode_reg)
    );

    int checks = 0;
    int errs = 0;
    bit finished = 0;

    bit          m_open[4];
    bit          m_pend[4];
    logic [10:0] m_mode = '0;
    bit          m_ckeq = 1'b1;
    logic [9:0]  e_cmd = '0;
    logic [1:0]  e_bank = '0;
    bit          e_ap = 0, e_ill = 0;

    task automatic model_step();
        int code;
        bit any_open, ill;
        int b;
        b = int'(ba);
        any_open = m_open[0] | m_open[1] | m_open[2] | m_open[3];
        if (!m_ckeq) begin
            e_cmd = '0; e_bank = '0; e_ap = 0; e_ill = 0;
        end else begin
            if (cs_n) code = 0;
            else case ({ras_n, cas_n, we_n})
                3'b111: code = 1;
                3'b011: code = 2;
                3'b010: code = addr[10] ? 4 : 3;
                3'b101: code = 5;
                3'b100: code = 6;
                3'b110: code = 7;
                3'b000: code = 8;
                default: code = 9;
            endcase
            ill = (code == 2 && m_open[b]) ||
                  ((code == 5 || code == 6) && !m_open[b]) ||
                  ((code == 8 || code == 9) && any_open);
            e_cmd  = 10'(1) << code;
            e_bank = (code == 0) ? 2'd0 : ba;
            e_ap   = (code == 5 || code == 6) && addr[10];
            e_ill  = ill;
            if (bdone && m_pend[dbank]) begin
                m_open[dbank] = 0;
                m_pend[dbank] = 0;
            end
            if (!ill) begin
                case (code)
                    2: begin m_open[b] = 1; m_pend[b] = 0; end
                    3: begin m_open[b] = 0; m_pend[b] = 0; end
                    4: for (int i = 0; i < 4; i++) begin m_open[i] = 0; m_pend[i] = 0; end
                    5, 6: begin m_open[b] = 1; m_pend[b] = addr[10]; end
                    8: m_mode = {addr[11], addr[9:0]};
                    default: ;
                endcase
            end
        end
        m_ckeq = cke;
    endtask

    task automatic check(input string tag);
        logic [3:0] e_open;
        e_open = {m_open[3], m_open[2], m_open[1], m_open[0]};
        checks++;
        if (cmd_onehot !== e_cmd || cmd_bank !== e_bank || auto_pre !== e_ap ||
            illegal !== e_ill || bank_open !== e_open || mode_reg !== m_mode) begin
            errs++;
            $display("FAIL %s: got cmd=%h bank=%0d ap=%0b ill=%0b open=%b mode=%h; expected cmd=%h bank=%0d ap=%0b ill=%0b open=%b mode=%h",
                     tag, cmd_onehot, cmd_bank, auto_pre, illegal, bank_open, mode_reg,
                     e_cmd, e_bank, e_ap, e_ill, e_open, m_mode);
        end
    endtask

    task automatic issue(input logic c, input logic r, input logic ca, input logic w,
                         input logic [1:0] b, input logic [11:0] a, input string tag);
        cs_n = c; ras_n = r; cas_n = ca; we_n = w; ba = b; addr = a;
        @(posedge clk);
        model_step();
        @(negedge clk);
        check(tag);
        bdone = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errs++;
            $display("FAIL R11 watchdog: got running, expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R11 reset state");

        issue(0, 1, 1, 1, 2'd0, 12'h000, "R3 nop");
        issue(1, 0, 1, 1, 2'd1, 12'h000, "R1 deselect masks activate");
        issue(0, 0, 1, 1, 2'd0, 12'h000, "R2 R4 activate bank0");
        issue(0, 0, 1, 1, 2'd2, 12'h000, "R4 activate bank2");
        issue(0, 0, 1, 1, 2'd0, 12'h123, "R4 re-activate open bank0");
        issue(0, 0, 0, 0, 2'd0, 12'h3FF, "R7 mode write with open banks");
        issue(0, 0, 0, 1, 2'd0, 12'h000, "R8 refresh with open banks");
        issue(0, 1, 0, 1, 2'd0, 12'h005, "R2 read bank0");
        issue(0, 1, 0, 0, 2'd2, 12'h408, "R6 write bank2 auto precharge");
        issue(0, 1, 0, 1, 2'd1, 12'h400, "R6 read idle bank1");
        issue(0, 1, 0, 0, 2'd3, 12'h000, "R6 write idle bank3");
        issue(0, 1, 1, 0, 2'd0, 12'h000, "R3 burst stop");
        bdone = 1'b1; dbank = 2'd0;
        issue(0, 1, 1, 1, 2'd0, 12'h000, "R9 completion without pending");
        bdone = 1'b1; dbank = 2'd2;
        issue(0, 1, 1, 1, 2'd0, 12'h000, "R9 completion closes bank2");
        issue(0, 0, 1, 0, 2'd0, 12'h000, "R5 precharge bank0");
        issue(0, 0, 1, 1, 2'd1, 12'h000, "R4 activate bank1");
        issue(0, 0, 1, 1, 2'd3, 12'h000, "R4 activate bank3");
        issue(0, 0, 1, 0, 2'd3, 12'h000, "R5 precharge bank3 only");
        issue(0, 0, 1, 0, 2'd2, 12'h400, "R5 precharge all");
        issue(0, 0, 1, 0, 2'd1, 12'h400, "R5 precharge all when idle");
        issue(0, 0, 0, 0, 2'd0, 12'hA35, "R7 mode write accepted");
        issue(0, 0, 0, 1, 2'd0, 12'h000, "R8 refresh legal");
        cke = 1'b0;
        issue(0, 1, 1, 1, 2'd0, 12'h000, "R10 cke drops");
        issue(0, 0, 1, 1, 2'd1, 12'h000, "R10 masked activate");
        cke = 1'b1;
        bdone = 1'b1; dbank = 2'd1;
        issue(0, 0, 1, 1, 2'd1, 12'h000, "R10 still masked");
        issue(0, 0, 1, 1, 2'd1, 12'h000, "R10 decode resumes");
        issue(0, 1, 0, 1, 2'd1, 12'h400, "R6 read bank1 auto precharge");
        bdone = 1'b1; dbank = 2'd1;
        issue(0, 1, 0, 1, 2'd1, 12'h000, "R9 same-edge read wins");

        for (int n = 0; n < 600; n++) begin
            logic [2:0] pins;
            pins = 3'($urandom);
            cke = ($urandom % 10) != 0;
            bdone = ($urandom % 4) == 0;
            dbank = 2'($urandom);
            issue(($urandom % 5) == 0, pins[2], pins[1], pins[0], 2'($urandom),
                  12'($urandom), "R2 random mix");
        end

        finished = 1;
        summary();
        $finish;
    end
endmodule